// File: doc/BRIEF.md
# Frame Routing Dispatcher

The dispatcher sits between a serial receiver and two peripherals: a ticket dispenser and a character LCD. When the receiver raises its frame-valid strobe, the dispatcher captures the 10-bit frame. It then forwards the upper nine bits as the payload to one destination, chosen by the frame's least significant bit.

On the dispenser path the dispatcher runs a full handshake. It holds the dispenser write strobe until the dispenser acknowledges, then waits for that acknowledge to drop again. On the LCD path it clears a hold counter for one cycle, then keeps the LCD write strobe high for a fixed, parameterised number of cycles.

Both paths end in a done state that signals completion to the receiver. The dispatcher stays in that state until frame-valid is withdrawn, so each frame is dispatched exactly once.

Top module: `frame_router`

## Requirements
- R1: While synchronous reset is high at a clock edge, the block enters the receive state; after that edge disp_wr, lcd_wr and done are all 0 and payload is 0.
- R2: In the receive state with frame_valid low, disp_wr, lcd_wr and done stay 0.
- R3: A frame accepted with frame_in[0]=1 raises disp_wr from the cycle after acceptance, with payload equal to frame_in[9:1] of the accepted frame.
- R4: disp_wr stays high until disp_ack is sampled high; it is low from the cycle after that edge.
- R5: After the dispenser write, done stays 0 while disp_ack remains high, and rises the cycle after disp_ack is sampled low.
- R6: A frame accepted with frame_in[0]=0 gives one cycle with no strobe, then lcd_wr high for exactly LCD_HOLD consecutive cycles (default 6), then done, with payload equal to frame_in[9:1].
- R7: done stays high while frame_valid is high, falls the cycle after frame_valid is sampled low, and no new dispatch starts until frame_valid is raised again.
- R8: payload comes from a register loaded at acceptance and does not change while either write strobe is high, even if frame_in changes.
- R9: disp_wr and lcd_wr are never high together, and neither is high while done is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_valid | input | 1 | Receiver has a frame ready |
| frame_in | input | 10 | Received frame; bit 0 selects the destination |
| disp_ack | input | 1 | Dispenser acknowledge (ticket taken) |
| disp_wr | output | 1 | Dispenser write strobe |
| lcd_wr | output | 1 | LCD write strobe |
| payload | output | 9 | Captured frame bits [9:1] |
| done | output | 1 | Frame handled; waits for frame_valid to drop |

## Verification
The assertions check properties that must hold on every cycle. These are: the exclusivity of the two strobes and of done, the reset outcome, the drop of disp_wr right after an acknowledge, the release of done once frame_valid falls, payload stability during a write, and an upper bound of LCD_HOLD on every LCD strobe run.

Some behaviour can only be shown by the bench's scenarios, where a per-cycle reference model is compared against the outputs. That includes correct routing by bit 0, the exact LCD strobe length, the one-cycle clear gap, and the wait for the acknowledge to fall. It also includes the check that a held frame_valid does not start a second dispatch.

// File: rtl/frame_router.sv
module frame_router #(
  parameter int LCD_HOLD = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_valid,
  input  logic [9:0] frame_in,
  input  logic       disp_ack,
  output logic       disp_wr,
  output logic       lcd_wr,
  output logic [8:0] payload,
  output logic       done
);
  localparam int CW = $clog2(LCD_HOLD + 1);
  localparam logic [CW-1:0] LAST = CW'(LCD_HOLD - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_DISP, S_DISP_EXIT, S_CLR, S_LCD, S_FIN
  } state_t;

  state_t          st;
  logic [CW-1:0]   cnt;
  logic [8:0]      pay_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      cnt   <= '0;
      pay_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (frame_valid) begin
          pay_q <= frame_in[9:1];
          st    <= frame_in[0] ? S_DISP : S_CLR;
        end
        S_DISP:      if (disp_ack) st <= S_DISP_EXIT;
        S_DISP_EXIT: if (!disp_ack) st <= S_FIN;
        S_CLR: begin
          cnt <= '0;
          st  <= S_LCD;
        end
        S_LCD: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) st <= S_FIN;
        end
        S_FIN:   if (!frame_valid) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign disp_wr = (st == S_DISP);
  assign lcd_wr  = (st == S_LCD);
  assign done    = (st == S_FIN);
  assign payload = pay_q;

  // R9: strobe exclusivity and quiet done
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(disp_wr && lcd_wr));
  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !(disp_wr || lcd_wr));

  // R1: reset outcome
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> !disp_wr && !lcd_wr && !done && payload == '0);

  // R4: dispenser strobe released after acknowledge
  assert_disp_release_R4: assert property (@(posedge clk) disable iff (rst)
    disp_wr && disp_ack |=> !disp_wr);

  // R7: done released once frame_valid drops
  assert_done_release_R7: assert property (@(posedge clk) disable iff (rst)
    done && !frame_valid |=> !done);

  // R8: payload held during writes
  assert_payload_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (disp_wr || lcd_wr) |=> !(disp_wr || lcd_wr) || $stable(payload));

  // R6: LCD strobe run never exceeds the hold time
  logic [CW:0] run_len;
  always_ff @(posedge clk) begin
    if (rst)         run_len <= '0;
    else if (lcd_wr) run_len <= run_len + 1'b1;
    else             run_len <= '0;
  end
  assert_lcd_run_R6: assert property (@(posedge clk) disable iff (rst)
    run_len <= (CW+1)'(LCD_HOLD));
endmodule

// File: tb/test_frame_router.sv
module test_frame_router;
  localparam int HOLD = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_valid = 1'b0;
  logic [9:0] frame_in = '0;
  logic       disp_ack = 1'b0;
  logic       disp_wr, lcd_wr, done;
  logic [8:0] payload;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  frame_router #(.LCD_HOLD(HOLD)) i_frame_router (
    .clk(clk), .rst(rst), .frame_valid(frame_valid), .frame_in(frame_in),
    .disp_ack(disp_ack), .disp_wr(disp_wr), .lcd_wr(lcd_wr),
    .payload(payload), .done(done)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: phase 0 wait, 1 dispenser write, 2 await ack low,
  // 3 clear gap, 4 LCD write, 5 finished.
  int         m_ph = 0;
  int         m_left = 0;
  logic [8:0] m_pay = '0;
  bit         started = 0;

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      m_ph = 0; m_pay = '0;
    end else begin
      case (m_ph)
        0: if (frame_valid) begin
             m_pay = frame_in[9:1];
             m_ph = frame_in[0] ? 1 : 3;
           end
        1: if (disp_ack) m_ph = 2;
        2: if (!disp_ack) m_ph = 5;
        3: begin m_ph = 4; m_left = HOLD; end
        4: begin m_left--; if (m_left == 0) m_ph = 5; end
        5: if (!frame_valid) m_ph = 0;
        default: m_ph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (started) begin
      check("R4", "disp_wr vs model", int'(disp_wr), int'(m_ph == 1));
      check("R6", "lcd_wr vs model", int'(lcd_wr), int'(m_ph == 4));
      check("R7", "done vs model", int'(done), int'(m_ph == 5));
      check("R8", "payload vs model", int'(payload), int'(m_pay));
      check("R9", "strobe overlap", int'((disp_wr && lcd_wr) || (done && (disp_wr || lcd_wr))), 0);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    step(2);
    check("R1", "disp_wr in reset", int'(disp_wr), 0);
    check("R1", "lcd_wr in reset", int'(lcd_wr), 0);
    check("R1", "done in reset", int'(done), 0);
    check("R1", "payload in reset", int'(payload), 0);
    rst = 1'b0;
    frame_in = 10'b1010010001;
    step(3);
    check("R2", "idle outputs", int'({disp_wr, lcd_wr, done}), 0);

    // dispenser path
    frame_valid = 1'b1;
    step(1);
    check("R3", "disp_wr after accept", int'(disp_wr), 1);
    check("R3", "payload dispenser", int'(payload), int'(9'b101001000));
    frame_in = 10'b0101010100;
    step(3);
    check("R4", "disp_wr held", int'(disp_wr), 1);
    check("R8", "payload stable", int'(payload), int'(9'b101001000));
    disp_ack = 1'b1;
    step(1);
    check("R4", "disp_wr dropped", int'(disp_wr), 0);
    step(2);
    check("R5", "done waits for ack low", int'(done), 0);
    disp_ack = 1'b0;
    step(1);
    check("R5", "done after ack low", int'(done), 1);
    step(2);
    check("R7", "done held with valid", int'(done), 1);
    frame_valid = 1'b0;
    step(1);
    check("R7", "done released", int'(done), 0);
    step(3);
    check("R7", "no redispatch", int'({disp_wr, lcd_wr, done}), 0);

    // LCD path
    frame_in = 10'b1011101010;
    frame_valid = 1'b1;
    step(1);
    check("R6", "clear gap", int'({disp_wr, lcd_wr}), 0);
    begin
      int run = 0;
      for (int i = 0; i < 40 && !done; i++) begin
        step(1);
        if (lcd_wr) run++;
        if (i == 1) check("R6", "payload lcd", int'(payload), int'(9'b101110101));
      end
      check("R6", "lcd_wr length", run, HOLD);
    end
    check("R6", "done after lcd", int'(done), 1);
    frame_valid = 1'b0;
    step(2);

    // quick acknowledge on a second dispenser frame
    frame_in = 10'b1111111111;
    frame_valid = 1'b1;
    disp_ack = 1'b1;
    step(1);
    check("R4", "disp_wr with ack already high", int'(disp_wr), 1);
    step(1);
    check("R4", "disp_wr one cycle", int'(disp_wr), 0);
    frame_valid = 1'b0;
    disp_ack = 1'b0;
    step(1);
    check("R5", "done", int'(done), 1);
    step(3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule